// File: doc/BRIEF.md
# Prime Modulo Cache Set Index Generator

This unit turns a 32-bit physical byte address into a second-level cache set index. The cache has 64-byte lines and 2048 physical sets. Only 2039 of those sets are used, because 2039 is prime. With a prime set count, power-of-two strides spread evenly over the sets instead of piling onto a few of them. The index is the block address (the byte address with the line offset removed) reduced modulo 2039. The nine highest physical sets stay unused.

The unit does not divide and does not multiply. The block address is cut into 11-bit chunks. Modulo 2039, a chunk at weight 2^11 counts as 9 times its value, and a chunk at weight 2^22 counts as 81 times its value. Each chunk is scaled by its constant with wired shifts and adds, and the scaled chunks are summed. Two fold stages then take every bit at weight 2^11 or above and add it back as 9 times its value. A final stage subtracts 2039 once and keeps whichever of the two candidates is not negative. An optional output register gives the unit one cycle of latency. Its valid flag follows the input strobe.

Top module: `pmod_index`

## Requirements
- R1: When `valid_i` is high, `index_o` one cycle later equals `addr_i[31:6]` modulo 2039. Bits [16:6] carry weight 1, bits [27:17] carry weight 2^11 and bits [31:28] carry weight 2^22.
- R2: While `valid_o` is high, `index_o` is always in the range 0 to 2038. Codes 2039 to 2047 never appear.
- R3: Address bits [5:0] (the line offset) have no effect on `index_o`.
- R4: `valid_o` equals `valid_i` from the preceding rising clock edge, so each strobed address yields exactly one result, one cycle later, and in order.
- R5: In a cycle after `valid_i` was low, `valid_o` is low and `index_o` keeps its previous value.
- R6: While `rst_ni` is low, `valid_o` is 0 and `index_o` is 0.
- R7: Block addresses that are exact multiples of 2039 give index 0. Block address 2039·k + r gives r, including r = 2038 and the values just past each wrap.
- R8: The result is correct at chunk boundaries. This covers a block address whose low chunk, middle chunk or top chunk is all ones, a block address where a carry crosses from one chunk into the next, and the all-ones address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address strobe |
| addr_i | input | 32 | Physical byte address |
| valid_o | output | 1 | Index valid, one cycle after valid_i |
| index_o | output | 11 | Set index, 0 to 2038 |

## Verification
The bench attacks the two wrap points of the reduction: block addresses just below, at and just above multiples of 2039, and the all-ones address, where the fold stages carry the most. Each wrap point catches its own fault. A final select that compares against the wrong constant, or does not subtract, lets codes 2039 to 2047 leak out. A dropped fold stage loses a carry and gives an index that is off by a multiple of 9. A swapped shift tap in the scale-by-81 path gives wrong results only when the top chunk is nonzero, so the bench drives each chunk on its own at its boundary values. Offset-only changes and idle gaps show an index that moves when it should hold, or a result that appears twice or never.

// File: rtl/pmod_pkg.sv
package pmod_pkg;

  // b^e mod m by repeated multiplication (elaboration only)
  function automatic int unsigned pow_mod(int unsigned b, int unsigned e, int unsigned m);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < e; i++) r = (r * b) % m;
    return r;
  endfunction

  // loose upper bound of the weighted chunk sum
  function automatic int unsigned sum_bound(int unsigned cw, int unsigned nch,
                                            int unsigned fold, int unsigned m);
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < nch; i++)
      s = s + ((32'd1 << cw) - 1) * pow_mod(fold, i, m);
    return s;
  endfunction

endpackage

// File: rtl/pmod_cmul.sv
// constant multiply built from wired shifts and adds
module pmod_cmul #(
  parameter int unsigned IN_W  = 11,
  parameter int unsigned K     = 9,
  parameter int unsigned OUT_W = 18
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] prod_o
);
  localparam int unsigned KW = $clog2(K + 1);

  logic [OUT_W-1:0] part [KW+1];
  assign part[0] = '0;

  for (genvar k = 0; k < KW; k++) begin : g_tap
    if (((K >> k) & 1) != 0) begin : g_on
      assign part[k+1] = part[k] + (OUT_W'(val_i) << k);
    end else begin : g_off
      assign part[k+1] = part[k];
    end
  end

  assign prod_o = part[KW];
endmodule

// File: rtl/pmod_fold.sv
// folds bits at weight 2^CW and above back as FOLD times their value
module pmod_fold #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned CW    = 11,
  parameter int unsigned FOLD  = 9,
  parameter int unsigned OUT_W = 12
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned HI_W = IN_W - CW;

  logic [HI_W-1:0]  hi;
  logic [CW-1:0]    lo;
  logic [OUT_W-1:0] hi_scaled;

  assign hi = val_i[IN_W-1:CW];
  assign lo = val_i[CW-1:0];

  pmod_cmul #(.IN_W(HI_W), .K(FOLD), .OUT_W(OUT_W)) u_mul (
    .val_i (hi),
    .prod_o(hi_scaled)
  );

  assign val_o = OUT_W'(lo) + hi_scaled;
endmodule

// File: rtl/pmod_subsel.sv
// two-candidate subtract and select: keeps s or s - MOD, whichever is non-negative
module pmod_subsel #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 11,
  parameter int unsigned MOD   = 2039
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] idx_o
);
  logic [IN_W:0] diff;
  logic          neg;

  assign diff = {1'b0, val_i} - (IN_W + 1)'(MOD);
  assign neg  = diff[IN_W];

  always_comb begin
    if (neg) idx_o = OUT_W'(val_i);
    else     idx_o = OUT_W'(diff);
  end
endmodule

// File: rtl/pmod_index.sv
module pmod_index #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFS_W   = 6,
  parameter int unsigned CHUNK_W  = 11,
  parameter int unsigned SET_CNT  = 2039,
  parameter int unsigned NUM_FOLD = 2,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               valid_o,
  output logic [CHUNK_W-1:0] index_o
);
  localparam int unsigned BLK_W   = ADDR_W - OFFS_W;
  localparam int unsigned NCHUNK  = (BLK_W + CHUNK_W - 1) / CHUNK_W;
  localparam int unsigned PAD_W   = NCHUNK * CHUNK_W;
  localparam int unsigned FOLD    = (1 << CHUNK_W) - SET_CNT;
  localparam int unsigned SUM_MAX = pmod_pkg::sum_bound(CHUNK_W, NCHUNK, FOLD, SET_CNT);
  localparam int unsigned SUM_W   = $clog2(SUM_MAX + 1);
  localparam int unsigned FW      = CHUNK_W + 1;

  logic [PAD_W-1:0] blk_pad;
  assign blk_pad = PAD_W'(addr_i >> OFFS_W);

  // weighted chunk terms
  logic [SUM_W-1:0] term [NCHUNK];
  logic [SUM_W-1:0] acc  [NCHUNK+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
    localparam int unsigned WGT = pmod_pkg::pow_mod(FOLD, i, SET_CNT);
    pmod_cmul #(.IN_W(CHUNK_W), .K(WGT), .OUT_W(SUM_W)) u_wgt (
      .val_i (blk_pad[i*CHUNK_W +: CHUNK_W]),
      .prod_o(term[i])
    );
    assign acc[i+1] = acc[i] + term[i];
  end

  // carry fold-back stages
  logic [FW-1:0] fold_v [NUM_FOLD];

  pmod_fold #(.IN_W(SUM_W), .CW(CHUNK_W), .FOLD(FOLD), .OUT_W(FW)) u_fold0 (
    .val_i(acc[NCHUNK]),
    .val_o(fold_v[0])
  );

  for (genvar f = 1; f < NUM_FOLD; f++) begin : g_fold
    pmod_fold #(.IN_W(FW), .CW(CHUNK_W), .FOLD(FOLD), .OUT_W(FW)) u_fold (
      .val_i(fold_v[f-1]),
      .val_o(fold_v[f])
    );
  end

  logic [CHUNK_W-1:0] idx_c;

  pmod_subsel #(.IN_W(FW), .OUT_W(CHUNK_W), .MOD(SET_CNT)) u_sel (
    .val_i(fold_v[NUM_FOLD-1]),
    .idx_o(idx_c)
  );

  if (REG_OUT) begin : g_reg
    logic               valid_q;
    logic [CHUNK_W-1:0] idx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) idx_q <= idx_c;
      end
    end
    assign valid_o = valid_q;
    assign index_o = idx_q;
  end else begin : g_comb
    assign valid_o = valid_i;
    assign index_o = idx_c;
  end
endmodule

// File: rtl/pmod_index_chk.sv
module pmod_index_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFFS_W  = 6,
  parameter int unsigned CHUNK_W = 11,
  parameter int unsigned SET_CNT = 2039,
  parameter bit          REG_OUT = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               valid_o,
  input logic [CHUNK_W-1:0] index_o
);
  if (REG_OUT) begin : g_chk
    // R2
    index_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (32'(index_o) < SET_CNT));

    // R1
    index_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (32'(index_o) == (32'($past(addr_i)) >> OFFS_W) % SET_CNT));

    // R4
    valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(index_o)));

    // R6
    always @(posedge clk_i) begin
      if (!rst_ni) begin
        reset_state_chk: assert (!valid_o && index_o == '0);
      end
    end
  end
endmodule

bind pmod_index pmod_index_chk #(
  .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .CHUNK_W(CHUNK_W),
  .SET_CNT(SET_CNT), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .addr_i (addr_i),
  .valid_o(valid_o),
  .index_o(index_o)
);

// File: tb/pmod_index_tb_top.sv
`timescale 1ns/1ps
module pmod_index_tb_top;
  localparam int unsigned SETS = 2039;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        valid_o;
  logic [10:0] index_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int    exp_q [$];
  string tag_q [$];
  int    last_idx = 0;

  always #2 clk_i = ~clk_i;

  pmod_index dut_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .addr_i (addr_i),
    .valid_o(valid_o),
    .index_o(index_o)
  );

  function automatic int ref_idx(logic [31:0] a);
    return int'((a >> 6) % SETS);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] a, string tag);
    @(negedge clk_i);
    valid_i = 1'b1;
    addr_i  = a;
    exp_q.push_back(ref_idx(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      addr_i  = $urandom;
    end
  endtask

  // monitor / scoreboard
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected valid_o", 1, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(index_o) == e, t, int'(index_o), e);
          check(int'(index_o) < SETS, "R2 index range", int'(index_o), SETS - 1);
        end
        last_idx = int'(index_o);
      end else begin
        check(int'(index_o) == last_idx, "R5 index hold while idle", int'(index_o), last_idx);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R4 watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6 reset state
    check(valid_o == 1'b0, "R6 valid_o in reset", int'(valid_o), 0);
    check(index_o == '0, "R6 index_o in reset", int'(index_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // R3 offset bits ignored
    drive(32'h0000_0000, "R3 offset zero");
    drive(32'h0000_003F, "R3 offset all ones");
    drive(32'h1234_5640, "R3 base");
    drive(32'h1234_567F, "R3 base with offset");
    idle(1);

    // R7 wrap points
    for (int k = 1; k < 6; k++) begin
      drive(32'((k * SETS) << 6), "R7 multiple of set count");
      drive(32'((k * SETS - 1) << 6), "R7 just below wrap");
      drive(32'((k * SETS + 1) << 6), "R7 just above wrap");
    end
    drive(32'((32'd32000 * SETS) << 6), "R7 large multiple");
    drive(32'(((32'd32000 * SETS) + 2038) << 6), "R7 large multiple plus 2038");
    idle(2);

    // R8 chunk boundaries
    drive(32'hFFFF_FFFF, "R8 all ones");
    drive(32'h0001_FFC0, "R8 low chunk all ones");
    drive(32'h0002_0000, "R8 carry into middle chunk");
    drive(32'h0FFE_0000, "R8 middle chunk all ones");
    drive(32'h0FFF_FFC0, "R8 low and middle all ones");
    drive(32'h1000_0000, "R8 carry into top chunk");
    drive(32'hF000_0000, "R8 top chunk all ones");
    drive(32'hF001_FFC0, "R8 top and low chunk");
    drive(32'hFFFE_0000, "R8 top and middle chunk");
    idle(3);

    // R1 random traffic with random gaps
    for (int i = 0; i < 3000; i++) begin
      drive($urandom, "R1 random address");
      if (($urandom % 4) == 0) idle(int'($urandom % 3) + 1);
    end
    idle(4);

    check(exp_q.size() == 0, "R4 results outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule